// File: doc/BRIEF.md
# Status Byte Summary and Service Request Generator

This block gathers the summary flags of an instrument's status reporting system into one 8-bit status byte. Five inputs arrive from the rest of the status system: a non-empty flag from the error queue, a data-ready flag from the output queue, and the summary bits of the standard-event, questionable and operational groups. Each input drives a fixed bit of the byte. Two bits always read as zero.

Bit 6 is the request-service bit. It is formed by masking the other seven bits with a writable 8-bit service-request mask and OR-reducing the result. Bit 6 of the mask takes no part in this, so the request bit never feeds back into itself. A registered copy of bit 6 drives an interrupt line. That line is free of glitches and trails the combinational bit by one clock.

A small register port carries a write strobe with data for the mask and a read select. The read select chooses between the live status byte and the stored mask. Reads are combinational and have no side effects.

Top module: `status_byte_srq`

## Requirements
- R1: Status byte bits 1 and 0 always read 0.
- R2: Status byte bit 2 equals the error-queue non-empty input in the same cycle.
- R3: Status byte bit 3 follows the questionable summary, bit 5 follows the standard-event summary and bit 7 follows the operational summary, each in the same cycle.
- R4: Status byte bit 4 equals the output-queue data-ready input in the same cycle.
- R5: Status byte bit 6 is 1 exactly when some bit i other than 6 has both status bit i and mask bit i set.
- R6: Mask bit 6 has no effect on status bit 6 or on the interrupt line.
- R7: The mask resets to 0x00. A write strobe loads the write data at the clock edge, and the new value appears on the read port and in the bit 6 computation from the next cycle.
- R8: Reads are free of side effects. With `rd_sel`=0 the read port returns the live status byte, and with `rd_sel`=1 it returns the mask. Selecting either one changes neither the mask nor the status byte.
- R9: The interrupt output resets to 0. After each clock edge it equals the value status bit 6 had just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_queue_nonempty | input | 1 | Error queue holds at least one entry |
| out_queue_ready | input | 1 | Output queue has data ready |
| std_event_sum | input | 1 | Standard-event group summary |
| quest_sum | input | 1 | Questionable group summary |
| oper_sum | input | 1 | Operational group summary |
| mask_wr | input | 1 | Write strobe for the service-request mask |
| mask_wdata | input | 8 | Write data for the mask |
| rd_sel | input | 1 | Read select: 0 status byte, 1 mask |
| rd_data | output | 8 | Read data |
| status_byte | output | 8 | Live status byte |
| srq_irq | output | 1 | Registered service-request interrupt |

## Verification
The critical overlap is a mask write that lands in the same cycle as a change on the summary inputs. In that cycle the request bit has to be formed from the old mask and the new inputs, the interrupt must then capture that value, and the new mask may act only from the next cycle. The bench drives both kinds of change on the same falling edge, and a behavioural model compares every output on every cycle. A second overlap, a mask readback issued in the same cycle as a mask write, must return the old value.

// File: rtl/srq_status_pkg.sv
package srq_status_pkg;
    // Width of the status byte and of the mask
    localparam int SB_WIDTH   = 8;
    // Fixed bit positions of the status byte
    localparam int POS_ERRQ   = 2;
    localparam int POS_QUEST  = 3;
    localparam int POS_OUTQ   = 4;
    localparam int POS_STDEV  = 5;
    localparam int POS_RQS    = 6;
    localparam int POS_OPER   = 7;

    // Read port selection
    typedef enum logic {
        RD_STATUS = 1'b0,
        RD_MASK   = 1'b1
    } rd_sel_e;

    // The summary inputs gathered together
    typedef struct packed {
        logic errq;
        logic outq;
        logic stdev;
        logic quest;
        logic oper;
    } summary_in_t;
endpackage

// File: rtl/srq_mask_reg.sv
// Service-request mask register.
// Holds the 8-bit mask. The mask loads on a write strobe and clears on reset.
// Assumes: a synchronous active-low reset; the write strobe is already qualified.
module srq_mask_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mask_q
);
    // Load the mask on a strobe, clear it on reset
    always_ff @(posedge clk) begin
        if (!rst_n)   mask_q <= '0;
        else if (wr)  mask_q <= wdata;
    end
endmodule

// File: rtl/srq_byte_assemble.sv
// Status byte assembly.
// Places each summary input at its fixed bit and inserts the request bit.
// Bits with no source are tied to zero.
// Assumes: the inputs are synchronous to the consumer and are not latched here.
module srq_byte_assemble
    import srq_status_pkg::*;
#(
    parameter int WIDTH = SB_WIDTH
) (
    input  summary_in_t      sum_in,
    input  logic             rqs,
    output logic [WIDTH-1:0] sbyte
);
    // Route each source to its fixed position; unused bits stay at zero
    always_comb begin
        sbyte            = '0;
        sbyte[POS_ERRQ]  = sum_in.errq;
        sbyte[POS_QUEST] = sum_in.quest;
        sbyte[POS_OUTQ]  = sum_in.outq;
        sbyte[POS_STDEV] = sum_in.stdev;
        sbyte[POS_RQS]   = rqs;
        sbyte[POS_OPER]  = sum_in.oper;
    end
endmodule

// File: rtl/srq_request.sv
// Request-service reduction.
// ANDs each status bit with its mask bit and ORs the products.
// The request position itself is left out, so the result cannot feed back.
// Assumes: the status-byte bit at RQS_POS is not an input here.
module srq_request #(
    parameter int WIDTH   = 8,
    parameter int RQS_POS = 6
) (
    input  logic [WIDTH-1:0] sbits,
    input  logic [WIDTH-1:0] mask,
    output logic             rqs
);
    logic [WIDTH-1:0] hit;

    // One AND gate per bit; the request position is forced to zero
    for (genvar i = 0; i < WIDTH; i++) begin : g_hit
        if (i == RQS_POS) begin : g_skip
            assign hit[i] = 1'b0;
        end else begin : g_and
            assign hit[i] = sbits[i] & mask[i];
        end
    end

    // OR-reduce the masked bits
    always_comb rqs = |hit;
endmodule

// File: rtl/status_byte_srq.sv
// Status byte with service request, top level.
// Builds the live status byte, keeps the request mask and drives a
// registered interrupt that trails status bit 6 by one cycle.
// Assumes: synchronous active-low reset; reads are combinational with no side effects.
module status_byte_srq
    import srq_status_pkg::*;
#(
    parameter int WIDTH   = SB_WIDTH,
    parameter int RQS_POS = POS_RQS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_queue_nonempty,
    input  logic             out_queue_ready,
    input  logic             std_event_sum,
    input  logic             quest_sum,
    input  logic             oper_sum,
    input  logic             mask_wr,
    input  logic [WIDTH-1:0] mask_wdata,
    input  logic             rd_sel,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] status_byte,
    output logic             srq_irq
);
    summary_in_t      sum_in;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] sbits_raw;
    logic             rqs;

    // Gather the summary inputs into one struct
    always_comb begin
        sum_in.errq  = err_queue_nonempty;
        sum_in.outq  = out_queue_ready;
        sum_in.stdev = std_event_sum;
        sum_in.quest = quest_sum;
        sum_in.oper  = oper_sum;
    end

    srq_mask_reg #(.WIDTH(WIDTH)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (mask_wr),
        .wdata  (mask_wdata),
        .mask_q (mask_q)
    );

    // The reduction sees the byte without the request bit, which avoids a loop
    srq_byte_assemble #(.WIDTH(WIDTH)) u_raw (
        .sum_in (sum_in),
        .rqs    (1'b0),
        .sbyte  (sbits_raw)
    );

    srq_request #(.WIDTH(WIDTH), .RQS_POS(RQS_POS)) u_req (
        .sbits (sbits_raw),
        .mask  (mask_q),
        .rqs   (rqs)
    );

    srq_byte_assemble #(.WIDTH(WIDTH)) u_byte (
        .sum_in (sum_in),
        .rqs    (rqs),
        .sbyte  (status_byte)
    );

    // Register the request bit so the interrupt line is free of glitches
    always_ff @(posedge clk) begin
        if (!rst_n) srq_irq <= 1'b0;
        else        srq_irq <= status_byte[RQS_POS];
    end

    // Combinational read port with no side effects
    always_comb rd_data = (rd_sel == RD_MASK) ? mask_q : status_byte;
endmodule

// File: rtl/status_byte_srq_chk.sv
// Property checker for status_byte_srq, attached to it by bind.
module status_byte_srq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       err_queue_nonempty,
    input logic       out_queue_ready,
    input logic       std_event_sum,
    input logic       quest_sum,
    input logic       oper_sum,
    input logic       mask_wr,
    input logic [7:0] mask_wdata,
    input logic       rd_sel,
    input logic [7:0] rd_data,
    input logic [7:0] status_byte,
    input logic       srq_irq,
    input logic [7:0] mask_q
);
    assert_low_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[1:0] == 2'b00);

    assert_errq_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[2] == err_queue_nonempty);

    assert_group_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[3] == quest_sum && status_byte[5] == std_event_sum
        && status_byte[7] == oper_sum);

    assert_outq_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[4] == out_queue_ready);

    // R5 and R6: request bit formed from the mask without its bit 6
    assert_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[6] == ((|(status_byte[5:0] & mask_q[5:0]))
                           || (status_byte[7] && mask_q[7])));

    assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> mask_q == $past(mask_wdata));

    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q));

    assert_irq_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> srq_irq == $past(status_byte[6]));
endmodule

bind status_byte_srq status_byte_srq_chk u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .err_queue_nonempty (err_queue_nonempty),
    .out_queue_ready    (out_queue_ready),
    .std_event_sum      (std_event_sum),
    .quest_sum          (quest_sum),
    .oper_sum           (oper_sum),
    .mask_wr            (mask_wr),
    .mask_wdata         (mask_wdata),
    .rd_sel             (rd_sel),
    .rd_data            (rd_data),
    .status_byte        (status_byte),
    .srq_irq            (srq_irq),
    .mask_q             (mask_q)
);

// File: tb/test_status_byte_srq.sv
`timescale 1ns/100ps
module test_status_byte_srq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       errq = 1'b0, outq = 1'b0, stdev = 1'b0, quest = 1'b0, oper = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       sel = 1'b0;
    logic [7:0] rd_data, status_byte;
    logic       srq_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model state
    logic [7:0] m_mask = 8'h00;
    logic       m_irq  = 1'b0;

    always #2.5 clk = ~clk;

    status_byte_srq i_status_byte_srq (
        .clk(clk), .rst_n(rst_n),
        .err_queue_nonempty(errq), .out_queue_ready(outq),
        .std_event_sum(stdev), .quest_sum(quest), .oper_sum(oper),
        .mask_wr(wr), .mask_wdata(wdata), .rd_sel(sel),
        .rd_data(rd_data), .status_byte(status_byte), .srq_irq(srq_irq)
    );

    function automatic logic [7:0] model_byte();
        logic [7:0] b;
        logic req;
        b = 8'h00;
        b[2] = errq; b[3] = quest; b[4] = outq; b[5] = stdev; b[7] = oper;
        req = 1'b0;
        for (int i = 0; i < 8; i++)
            if (i != 6 && b[i] && m_mask[i]) req = 1'b1;
        b[6] = req;
        return b;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model
    task automatic compare();
        logic [7:0] e;
        e = model_byte();
        check("R1", {6'd0, status_byte[1:0]}, {6'd0, e[1:0]});
        check("R2", {7'd0, status_byte[2]}, {7'd0, e[2]});
        check("R3", {5'd0, status_byte[7], status_byte[5], status_byte[3]},
                    {5'd0, e[7], e[5], e[3]});
        check("R4", {7'd0, status_byte[4]}, {7'd0, e[4]});
        check("R5", {7'd0, status_byte[6]}, {7'd0, e[6]});
        check("R9", {7'd0, srq_irq}, {7'd0, m_irq});
        if (sel) check("R7", rd_data, m_mask);
        else     check("R8", rd_data, e);
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model at the rising edge
    task automatic step(input logic rs, input logic [4:0] s, input logic w,
                        input logic [7:0] d, input logic rsel);
        logic [7:0] pre;
        @(negedge clk);
        rst_n = rs; {errq, outq, stdev, quest, oper} = s;
        wr = w; wdata = d; sel = rsel;
        #1;
        compare();
        pre = model_byte();
        @(posedge clk);
        if (!rs) begin
            m_mask = 8'h00; m_irq = 1'b0;
        end else begin
            m_irq = pre[6];
            if (w) m_mask = d;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Reset state (R7, R9); bits were unknown before the first edge
        step(0, 5'b11111, 1, 8'hFF, 1);
        step(0, 5'b00000, 0, 8'h00, 1);
        step(1, 5'b00000, 0, 8'h00, 1);
        // Walk each input with the mask at zero (R1-R4)
        for (int i = 0; i < 5; i++) step(1, 5'b00001 << i, 0, 8'h00, 0);
        // Only mask bit 6 set with every input high: no request (R6)
        step(1, 5'b11111, 1, 8'h40, 1);
        step(1, 5'b11111, 0, 8'h00, 1);
        step(1, 5'b11111, 0, 8'h00, 0);
        // Each mask bit paired with its source (R5)
        for (int b = 2; b < 8; b++) begin
            if (b == 6) continue;
            step(1, 5'b00000, 1, 8'h01 << b, 1);
            step(1, 5'b11111, 0, 8'h00, 0);
            step(1, 5'b00000, 0, 8'h00, 0);
        end
        // Mask write and input change in the same cycle; readback of the old mask (R7, R9)
        step(1, 5'b00000, 1, 8'h04, 1);
        step(1, 5'b10000, 1, 8'h80, 1);
        step(1, 5'b00010, 1, 8'h10, 1);
        step(1, 5'b00010, 0, 8'h00, 0);
        // Reads leave the state unchanged (R8)
        for (int k = 0; k < 6; k++) step(1, 5'b01010, 0, 8'h00, k[0]);
        // Pseudo-random run
        for (int n = 0; n < 300; n++) begin
            int r;
            r = (n * 37 + 11) ^ (n >> 2);
            step(1, r[4:0], r[5] & r[7], r[15:8] ^ 8'h5A, r[6]);
        end
        // Reset mid-run clears the mask and the interrupt (R7, R9)
        step(1, 5'b11111, 1, 8'hFF, 0);
        step(0, 5'b11111, 0, 8'h00, 1);
        step(1, 5'b11111, 0, 8'h00, 1);
        step(1, 5'b11111, 0, 8'h00, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule